// File: doc/BRIEF.md
# Block-Transfer Mailbox Register Block

This block sits between a byte-wide host register port and a management controller and carries whole messages between the two in block form. The host sees three byte registers: a control and status register, a data port, and an interrupt-mask register. Host writes to the data port load the host-to-controller buffer one byte at a time, and a write pointer advances on each write. Host reads of the data port unload the controller-to-host buffer, and a read pointer advances on each read. A message in either buffer starts with a length byte, followed by net function, sequence and command bytes, then the payload. A response has one more byte, a completion code, placed after the command.

The host never does read-modify-write on the control register. A 1 written to a control bit sets, clears or toggles that bit, depending on the bit, and a 0 leaves it alone. The host follows a fixed sequence. It clears the write pointer, streams a request, then raises the host-to-controller attention bit. To fetch a reply, the host sets host-busy, clears the attention bit in a separate write, clears the read pointer, streams the reply out, and toggles host-busy back.

The controller side has indexed access to both buffers, one-cycle pulses to raise or drop attention flags, a controller-busy input, and a one-cycle reset request. The interrupt-mask register drives that reset request.

Top module: `bt_mbox_regs`

## Requirements
- R1: After reset every control flag is 0, the mask reads 0, both pointers are 0, `host_irq_o` and `ctl_reset_req_o` are 0, and `mbox_idle_o` is 1 while `ctl_busy_i` is 0.
- R2: Writing 0x00 to the control register at offset 0xE4 changes no flag.
- R3: Writing 1 to control bit 6 (host-busy) toggles it. Writing 1 to bit 5 (general-purpose flag) toggles it.
- R4: Control bits 4 (event attention) and 3 (controller-to-host attention) are cleared by a host 1 and set by `ctl_sms_set_i` / `ctl_c2h_set_i`. A controller set wins over a host clear in the same cycle.
- R5: Control bit 2 (host-to-controller attention) is set by a host 1 and cleared by `ctl_h2c_clr_i`. A host set wins over a controller clear in the same cycle.
- R6: Control bit 7 reads `ctl_busy_i`, and host writes to it have no effect. Bits 1 and 0 always read 0.
- R7: Writing 1 to bit 0 returns the write pointer to index 0. Writing 1 to bit 1 returns the read pointer to index 0.
- R8: A host write to offset 0xE5 stores the byte at the write pointer of the host-to-controller buffer and advances the pointer. The controller reads that buffer by index through `ctl_h2c_addr_i`.
- R9: A host read of offset 0xE5 returns the controller-to-host byte at the read pointer and then advances the pointer. The controller fills that buffer by index.
- R10: Both pointers wrap modulo the buffer depth of 64 bytes.
- R11: In the mask register at 0xE6, bit 0 enables the interrupt for controller-to-host attention and bit 1 enables it for event attention. `host_irq_o` is the OR of the enabled flags. Reads return bits 1:0, and the other bits read 0.
- R12: Writing 1 to mask bit 7 pulses `ctl_reset_req_o` for one cycle. Bit 7 reads 0.
- R13: `mbox_idle_o` is 1 only when controller-busy and all three attention flags are 0.
- R14: A write to any other offset changes nothing, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_sel_i | input | 1 | Host register access strobe, one cycle per access |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 8 | Register byte offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data for `host_addr_i`, combinational |
| host_irq_o | output | 1 | Interrupt to host |
| ctl_busy_i | input | 1 | Controller-busy flag |
| ctl_c2h_set_i | input | 1 | Pulse: raise controller-to-host attention |
| ctl_sms_set_i | input | 1 | Pulse: raise event attention |
| ctl_h2c_clr_i | input | 1 | Pulse: drop host-to-controller attention |
| ctl_h2c_atn_o | output | 1 | Host-to-controller attention flag |
| ctl_host_busy_o | output | 1 | Host-busy flag |
| ctl_reset_req_o | output | 1 | One-cycle reset request to controller |
| ctl_h2c_addr_i | input | 6 | Controller read index into host-to-controller buffer |
| ctl_h2c_rdata_o | output | 8 | Byte at `ctl_h2c_addr_i` |
| ctl_c2h_we_i | input | 1 | Controller write strobe for controller-to-host buffer |
| ctl_c2h_addr_i | input | 6 | Controller write index |
| ctl_c2h_wdata_i | input | 8 | Controller write data |
| mbox_idle_o | output | 1 | Interface idle |

## Verification
The hardest situations to reach are a host control write and a controller pulse that target the same flag in the same cycle. In this case the priority decides whether an attention is lost. The vector table drives a controller event in the same cycle as the host write, for both the set-wins and the host-wins flags. Pointer wrap needs 65 back-to-back data accesses after a pointer clear, so the bench streams a full buffer plus one byte in each direction and checks which index the extra byte landed on or came from.

// File: rtl/bt_mbox_pkg.sv
package bt_mbox_pkg;
  localparam int unsigned DATA_W = 8;

  // control register bit positions (host-visible layout)
  localparam int unsigned CB_CTL_BUSY  = 7;
  localparam int unsigned CB_HOST_BUSY = 6;
  localparam int unsigned CB_GP_FLAG   = 5;
  localparam int unsigned CB_EVT_ATN   = 4;
  localparam int unsigned CB_C2H_ATN   = 3;
  localparam int unsigned CB_H2C_ATN   = 2;
  localparam int unsigned CB_CLR_RD    = 1;
  localparam int unsigned CB_CLR_WR    = 0;

  // mask register bit positions
  localparam int unsigned MB_RST_REQ = 7;
  localparam int unsigned MB_EVT_EN  = 1;
  localparam int unsigned MB_C2H_EN  = 0;

  typedef struct packed {
    logic host_busy;
    logic gp_flag;
    logic evt_atn;
    logic c2h_atn;
    logic h2c_atn;
  } mbox_flags_t;
endpackage

// File: rtl/bt_ctrl_flags.sv
module bt_ctrl_flags
  import bt_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              c2h_set_i,
  input  logic              evt_set_i,
  input  logic              h2c_clr_i,
  output mbox_flags_t       flags_o
);
  mbox_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (wr_i && wdata_i[CB_HOST_BUSY]) flags_d.host_busy = ~flags_q.host_busy;
    if (wr_i && wdata_i[CB_GP_FLAG])   flags_d.gp_flag   = ~flags_q.gp_flag;
    // controller raise beats host clear
    if (evt_set_i)                          flags_d.evt_atn = 1'b1;
    else if (wr_i && wdata_i[CB_EVT_ATN])   flags_d.evt_atn = 1'b0;
    if (c2h_set_i)                          flags_d.c2h_atn = 1'b1;
    else if (wr_i && wdata_i[CB_C2H_ATN])   flags_d.c2h_atn = 1'b0;
    // host raise beats controller clear
    if (wr_i && wdata_i[CB_H2C_ATN])        flags_d.h2c_atn = 1'b1;
    else if (h2c_clr_i)                     flags_d.h2c_atn = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_ZERO_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0 && !c2h_set_i && !evt_set_i && !h2c_clr_i) |=> $stable(flags_q)); // R2
  AST_BUSY_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CB_HOST_BUSY]) |=> (flags_q.host_busy != $past(flags_q.host_busy))); // R3
  AST_C2H_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c2h_set_i |=> flags_q.c2h_atn); // R4
  AST_EVT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i |=> flags_q.evt_atn); // R4
  AST_H2C_HOST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CB_H2C_ATN]) |=> flags_q.h2c_atn); // R5
endmodule

// File: rtl/bt_msg_buf.sv
module bt_msg_buf
  import bt_mbox_pkg::*;
#(
  parameter int unsigned DEPTH       = 64,
  parameter bit          HOST_WRITES = 1'b1,
  localparam int unsigned AW         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_clr_i,
  input  logic              host_acc_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              ctl_we_i,
  input  logic [AW-1:0]     ctl_addr_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  output logic [DATA_W-1:0] ctl_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     ptr_q;

  // pointer wraps naturally at power-of-two depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_clr_i)  ptr_q <= '0;
    else if (host_acc_i) ptr_q <= ptr_q + 1'b1;
  end

  generate
    if (HOST_WRITES) begin : g_host_wr
      always_ff @(posedge clk_i) begin
        if (host_acc_i) mem_q[ptr_q] <= host_wdata_i;
      end
      logic unused_ctl_wr;
      assign unused_ctl_wr = ^{ctl_we_i, ctl_wdata_i};
    end else begin : g_ctl_wr
      always_ff @(posedge clk_i) begin
        if (ctl_we_i) mem_q[ctl_addr_i] <= ctl_wdata_i;
      end
      logic unused_host_wr;
      assign unused_host_wr = ^host_wdata_i;
    end
  endgenerate

  assign host_rdata_o = mem_q[ptr_q];
  assign ctl_rdata_o  = mem_q[ctl_addr_i];

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_acc_i && !ptr_clr_i) |=> (ptr_q == AW'($past(ptr_q) + 1))); // R10
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> (ptr_q == '0)); // R7
endmodule

// File: rtl/bt_irq_mask.sv
module bt_irq_mask
  import bt_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              c2h_atn_i,
  input  logic              evt_atn_i,
  output logic [1:0]        mask_o,
  output logic              irq_o,
  output logic              reset_req_o
);
  logic [1:0] mask_q;
  logic       rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wr_i && wdata_i[MB_RST_REQ];
      if (wr_i) mask_q <= {wdata_i[MB_EVT_EN], wdata_i[MB_C2H_EN]};
    end
  end

  assign mask_o      = mask_q;
  assign irq_o       = (c2h_atn_i & mask_q[0]) | (evt_atn_i & mask_q[1]);
  assign reset_req_o = rst_req_q;

  AST_RST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[MB_RST_REQ]) |=> reset_req_o); // R12
  AST_RST_REQ_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && wdata_i[MB_RST_REQ]) |=> !reset_req_o); // R12
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 2'b00) |-> !irq_o); // R11
endmodule

// File: rtl/bt_mbox_regs.sv
module bt_mbox_regs
  import bt_mbox_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  OFS_CTRL  = 8'hE4,
  parameter logic [7:0]  OFS_DATA  = 8'hE5,
  parameter logic [7:0]  OFS_IMASK = 8'hE6,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_irq_o,
  input  logic              ctl_busy_i,
  input  logic              ctl_c2h_set_i,
  input  logic              ctl_sms_set_i,
  input  logic              ctl_h2c_clr_i,
  output logic              ctl_h2c_atn_o,
  output logic              ctl_host_busy_o,
  output logic              ctl_reset_req_o,
  input  logic [AW-1:0]     ctl_h2c_addr_i,
  output logic [DATA_W-1:0] ctl_h2c_rdata_o,
  input  logic              ctl_c2h_we_i,
  input  logic [AW-1:0]     ctl_c2h_addr_i,
  input  logic [DATA_W-1:0] ctl_c2h_wdata_i,
  output logic              mbox_idle_o
);
  logic hit_ctrl, hit_data, hit_mask;
  logic ctrl_wr, data_wr, data_rd, mask_wr;
  mbox_flags_t flags;
  logic [1:0]        mask;
  logic [DATA_W-1:0] ctrl_rd, c2h_host_rd, h2c_host_rd_unused, c2h_ctl_rd_unused;

  assign hit_ctrl = (host_addr_i == ADDR_W'(OFS_CTRL));
  assign hit_data = (host_addr_i == ADDR_W'(OFS_DATA));
  assign hit_mask = (host_addr_i == ADDR_W'(OFS_IMASK));
  assign ctrl_wr  = host_sel_i &&  host_we_i && hit_ctrl;
  assign data_wr  = host_sel_i &&  host_we_i && hit_data;
  assign data_rd  = host_sel_i && !host_we_i && hit_data;
  assign mask_wr  = host_sel_i &&  host_we_i && hit_mask;

  bt_ctrl_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (host_wdata_i),
    .c2h_set_i (ctl_c2h_set_i),
    .evt_set_i (ctl_sms_set_i),
    .h2c_clr_i (ctl_h2c_clr_i),
    .flags_o   (flags)
  );

  bt_msg_buf #(.DEPTH(DEPTH), .HOST_WRITES(1'b1)) u_h2c_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_clr_i    (ctrl_wr && host_wdata_i[CB_CLR_WR]),
    .host_acc_i   (data_wr),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (h2c_host_rd_unused),
    .ctl_we_i     (1'b0),
    .ctl_addr_i   (ctl_h2c_addr_i),
    .ctl_wdata_i  ('0),
    .ctl_rdata_o  (ctl_h2c_rdata_o)
  );

  bt_msg_buf #(.DEPTH(DEPTH), .HOST_WRITES(1'b0)) u_c2h_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_clr_i    (ctrl_wr && host_wdata_i[CB_CLR_RD]),
    .host_acc_i   (data_rd),
    .host_wdata_i ('0),
    .host_rdata_o (c2h_host_rd),
    .ctl_we_i     (ctl_c2h_we_i),
    .ctl_addr_i   (ctl_c2h_addr_i),
    .ctl_wdata_i  (ctl_c2h_wdata_i),
    .ctl_rdata_o  (c2h_ctl_rd_unused)
  );

  bt_irq_mask u_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (mask_wr),
    .wdata_i     (host_wdata_i),
    .c2h_atn_i   (flags.c2h_atn),
    .evt_atn_i   (flags.evt_atn),
    .mask_o      (mask),
    .irq_o       (host_irq_o),
    .reset_req_o (ctl_reset_req_o)
  );

  always_comb begin
    ctrl_rd               = '0;
    ctrl_rd[CB_CTL_BUSY]  = ctl_busy_i;
    ctrl_rd[CB_HOST_BUSY] = flags.host_busy;
    ctrl_rd[CB_GP_FLAG]   = flags.gp_flag;
    ctrl_rd[CB_EVT_ATN]   = flags.evt_atn;
    ctrl_rd[CB_C2H_ATN]   = flags.c2h_atn;
    ctrl_rd[CB_H2C_ATN]   = flags.h2c_atn;
  end

  always_comb begin
    host_rdata_o = '0;
    if (hit_ctrl)      host_rdata_o = ctrl_rd;
    else if (hit_data) host_rdata_o = c2h_host_rd;
    else if (hit_mask) host_rdata_o = {{(DATA_W-2){1'b0}}, mask};
  end

  assign ctl_h2c_atn_o   = flags.h2c_atn;
  assign ctl_host_busy_o = flags.host_busy;
  assign mbox_idle_o     = !(ctl_busy_i || flags.evt_atn || flags.c2h_atn || flags.h2c_atn);

  logic unused_rd;
  assign unused_rd = ^{h2c_host_rd_unused, c2h_ctl_rd_unused};

  AST_IDLE_BLOCKED_BY_H2C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && host_wdata_i[CB_H2C_ATN] |=> !mbox_idle_o); // R13
  AST_STRAY_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i && host_we_i && !hit_ctrl && !hit_data && !hit_mask
     && !ctl_c2h_set_i && !ctl_sms_set_i && !ctl_h2c_clr_i) |=> $stable(flags)); // R14
endmodule

// File: tb/tb_bt_mbox_regs.sv
module tb_bt_mbox_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       host_sel_i = 1'b0, host_we_i = 1'b0;
  logic [7:0] host_addr_i = '0, host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_irq_o;
  logic       ctl_busy_i = 1'b0, ctl_c2h_set_i = 1'b0, ctl_sms_set_i = 1'b0, ctl_h2c_clr_i = 1'b0;
  logic       ctl_h2c_atn_o, ctl_host_busy_o, ctl_reset_req_o;
  logic [5:0] ctl_h2c_addr_i = '0;
  logic [7:0] ctl_h2c_rdata_o;
  logic       ctl_c2h_we_i = 1'b0;
  logic [5:0] ctl_c2h_addr_i = '0;
  logic [7:0] ctl_c2h_wdata_i = '0;
  logic       mbox_idle_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  bt_mbox_regs dut (.*);

  // {host write data, controller events {c2h_set, sms_set, h2c_clr}, expected control readback}
  localparam logic [23:0] VEC [15] = '{
    24'h00_00_00, 24'h04_00_04, 24'h00_04_0C, 24'h00_02_1C, 24'h08_00_14,
    24'h40_00_54, 24'h10_00_44, 24'h40_00_04, 24'h20_00_24, 24'h00_01_20,
    24'h08_04_28, 24'h04_01_2C, 24'h03_00_2C, 24'h28_00_04, 24'h00_01_00
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [7:0] d, input logic [2:0] ev);
    @(negedge clk_i);
    host_sel_i = 1; host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    {ctl_c2h_set_i, ctl_sms_set_i, ctl_h2c_clr_i} = ev;
    @(negedge clk_i);
    host_sel_i = 0; host_we_i = 0;
    {ctl_c2h_set_i, ctl_sms_set_i, ctl_h2c_clr_i} = '0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    host_sel_i = 1; host_we_i = 0; host_addr_i = a;
    #1 d = host_rdata_o;
    @(negedge clk_i);
    host_sel_i = 0;
  endtask

  task automatic cw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    ctl_c2h_we_i = 1; ctl_c2h_addr_i = a; ctl_c2h_wdata_i = d;
    @(negedge clk_i);
    ctl_c2h_we_i = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    hr(8'hE4, r); chk("R1 ctrl", r, 8'h00);
    hr(8'hE6, r); chk("R1 mask", r, 8'h00);
    chk("R1 irq", {7'b0, host_irq_o}, 8'h00);
    chk("R1 rstreq", {7'b0, ctl_reset_req_o}, 8'h00);
    chk("R1 idle", {7'b0, mbox_idle_o}, 8'h01);

    // control-register vector walk: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      hw(8'hE4, VEC[i][23:16], VEC[i][10:8]);
      hr(8'hE4, r);
      chk($sformatf("R2/R3/R4/R5/R6 vec%0d", i), r, VEC[i][7:0]);
    end
    chk("R13 idle after table", {7'b0, mbox_idle_o}, 8'h01);

    // R6 controller-busy visible, host write has no effect
    ctl_busy_i = 1;
    hw(8'hE4, 8'h80, 3'b000);
    hr(8'hE4, r); chk("R6 busy bit", r, 8'h80);
    chk("R13 busy blocks idle", {7'b0, mbox_idle_o}, 8'h00);
    ctl_busy_i = 0;
    hr(8'hE4, r); chk("R6 write ignored", r, 8'h00);
    hw(8'hE4, 8'h04, 3'b000);
    chk("R13 h2c blocks idle", {7'b0, mbox_idle_o}, 8'h00);
    chk("R5 h2c out", {7'b0, ctl_h2c_atn_o}, 8'h01);
    hw(8'hE4, 8'h00, 3'b001);
    hw(8'hE4, 8'h40, 3'b000);
    chk("R3 host busy out", {7'b0, ctl_host_busy_o}, 8'h01);
    hw(8'hE4, 8'h40, 3'b000);

    // R8 host fills request buffer
    hw(8'hE4, 8'h01, 3'b000);
    for (int k = 0; k < 5; k++) hw(8'hE5, 8'h30 + 8'(k), 3'b000);
    for (int k = 0; k < 5; k++) begin
      ctl_h2c_addr_i = 6'(k); #1;
      chk($sformatf("R8 h2c idx%0d", k), ctl_h2c_rdata_o, 8'h30 + 8'(k));
    end
    // R7 write pointer clear
    hw(8'hE4, 8'h01, 3'b000);
    hw(8'hE5, 8'hAA, 3'b000);
    ctl_h2c_addr_i = 6'd0; #1; chk("R7 wr ptr cleared", ctl_h2c_rdata_o, 8'hAA);
    ctl_h2c_addr_i = 6'd1; #1; chk("R7 idx1 kept", ctl_h2c_rdata_o, 8'h31);

    // R9 controller fills reply buffer, host drains
    for (int k = 0; k < 64; k++) cw(6'(k), 8'(k) ^ 8'h5A);
    hw(8'hE4, 8'h02, 3'b000);
    for (int k = 0; k < 3; k++) begin
      hr(8'hE5, r); chk($sformatf("R9 c2h idx%0d", k), r, 8'(k) ^ 8'h5A);
    end
    hw(8'hE4, 8'h02, 3'b000);
    hr(8'hE5, r); chk("R7 rd ptr cleared", r, 8'h5A);

    // R10 wrap on both pointers
    hw(8'hE4, 8'h02, 3'b000);
    for (int k = 0; k < 64; k++) hr(8'hE5, r);
    hr(8'hE5, r); chk("R10 rd wrap", r, 8'h5A);
    hw(8'hE4, 8'h01, 3'b000);
    for (int k = 0; k < 65; k++) hw(8'hE5, 8'h80 + 8'(k), 3'b000);
    ctl_h2c_addr_i = 6'd0; #1; chk("R10 wr wrap", ctl_h2c_rdata_o, 8'hC0);
    ctl_h2c_addr_i = 6'd1; #1; chk("R10 wr wrap idx1", ctl_h2c_rdata_o, 8'h81);

    // R11 interrupt masking
    hw(8'hE4, 8'h00, 3'b100);
    chk("R11 masked", {7'b0, host_irq_o}, 8'h00);
    hw(8'hE6, 8'h01, 3'b000);
    chk("R11 c2h enabled", {7'b0, host_irq_o}, 8'h01);
    hr(8'hE6, r); chk("R11 mask readback", r, 8'h01);
    hw(8'hE6, 8'h7E, 3'b000);
    chk("R11 evt only", {7'b0, host_irq_o}, 8'h00);
    hr(8'hE6, r); chk("R11 upper bits read 0", r, 8'h02);
    hw(8'hE4, 8'h00, 3'b010);
    chk("R11 evt irq", {7'b0, host_irq_o}, 8'h01);
    hw(8'hE4, 8'h18, 3'b000);
    chk("R11 cleared", {7'b0, host_irq_o}, 8'h00);

    // R12 reset request pulse
    hw(8'hE6, 8'h80, 3'b000);
    chk("R12 pulse high", {7'b0, ctl_reset_req_o}, 8'h01);
    @(negedge clk_i);
    chk("R12 pulse low", {7'b0, ctl_reset_req_o}, 8'h00);
    hr(8'hE6, r); chk("R12 bit7 reads 0", r, 8'h00);

    // R14 unmapped offset
    hw(8'hE7, 8'hFF, 3'b000);
    hr(8'hE7, r); chk("R14 read 0", r, 8'h00);
    hr(8'hE4, r); chk("R14 ctrl untouched", r, 8'h00);
    hr(8'hE6, r); chk("R14 mask untouched", r, 8'h00);

    summary();
  end
endmodule